// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block sends asynchronous serial frames from a one-word holding buffer placed in front of a shift register. The host writes a word into the holding buffer. When the shift register is free, the block moves the word into it and drives the frame onto the line. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop period. The stop period can be half, one, one and a half or two bit times. All timing comes from an oversample tick that runs at 16 times the baud rate. An external programmable divider produces this tick.

Because of the buffer, the host can queue the next word while the current frame is still on the line. Two flags report progress. The empty flag says the buffer can take a word. The complete flag says the line has gone quiet after the last frame. Each flag has its own interrupt enable. Frames go out only while both the peripheral enable and the transmitter enable are high.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line output is 1, the empty flag is 1, the complete flag is 1 and both interrupt outputs are 0 while their enables are 0.
- R2: No frame starts unless `en_i` and `tx_en_i` are both 1. A buffered word waits, and the line stays at 1, until both are 1.
- R3: A write while the empty flag is 1 stores `wr_data_i` and clears both the empty flag and the complete flag. A write while the empty flag is 0 is dropped and never transmitted.
- R4: The empty flag returns to 1 once the buffered word has been moved into the shift register, while that frame is still being sent.
- R5: A frame is one start bit at 0, then the data bits least significant first. `wide_i`=0 sends bits 7..0. `wide_i`=1 sends bits 8..0.
- R6: The `stop_sel_i` field sets the high stop period in oversample ticks: 00 gives 16, 01 gives 8, 10 gives 32, 11 gives 24.
- R7: If a word is waiting when a stop period ends, its start bit begins on the next cycle with no idle gap. The complete flag stays 0 across the boundary.
- R8: The complete flag becomes 1 only when a stop period ends with the buffer empty. The line is then at 1.
- R9: `txe_irq_o` equals `txe_ie_i` AND the empty flag. `tc_irq_o` equals `tc_ie_i` AND the complete flag.
- R10: The start bit and each data bit last 16 oversample ticks. Between two back-to-back frame starts there are (1+N)*16 ticks plus the stop length, where N is the number of data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Peripheral enable |
| tx_en_i | input | 1 | Transmitter enable |
| wide_i | input | 1 | 0: 8 data bits, 1: 9 data bits |
| stop_sel_i | input | 2 | Stop length code |
| tick_i | input | 1 | Oversample tick at 16x the baud rate, one cycle wide |
| wr_i | input | 1 | Host write strobe for the holding buffer |
| wr_data_i | input | 9 | Word to buffer |
| txe_ie_i | input | 1 | Empty-flag interrupt enable |
| tc_ie_i | input | 1 | Complete-flag interrupt enable |
| tx_o | output | 1 | Serial line, idle high |
| txe_o | output | 1 | Holding buffer empty flag |
| tc_o | output | 1 | Transmission complete flag |
| txe_irq_o | output | 1 | Empty interrupt |
| tc_irq_o | output | 1 | Complete interrupt |

## Verification
The hardest case to reach is the stop-to-start handover. A second word must already sit in the buffer when the stop period of the previous frame ends. Only then can the bench measure the exact stop length and confirm that the complete flag never rises between the frames. The bench gets there by queuing a third word as soon as the empty flag shows that the second word has moved into the shift register. It uses data whose last bit is 0, so that the rising edge at the start of the stop period and the falling edge of the next start bit can both be timed to the cycle. Random words, widths and stop codes, some of them queued in pairs, then exercise the remaining combinations.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // stop length in oversample ticks; code order is fixed by the register field
  function automatic int stop_ticks(input logic [1:0] sel, input int os);
    case (sel)
      2'b01:   return os / 2;
      2'b10:   return 2 * os;
      2'b11:   return os + os / 2;
      default: return os;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic         accept_o,
  output logic [W-1:0] data_o
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign accept_o = wr_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept_o) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  p_wr_fills_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_q) |=> full_q);

  p_full_keeps_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_q && !take_i) |=> (full_q && data_q == $past(data_q)));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int W  = 9,
  parameter int OS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         wide_i,
  input  logic [1:0]   stop_sel_i,
  input  logic         pend_i,
  input  logic [W-1:0] pend_data_i,
  output logic         take_o,
  output logic         done_o,
  output logic         tx_o
);

  localparam int CW = $clog2(2 * OS + 1);
  localparam int BW = $clog2(W);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  sh_q;

  logic          adv;
  logic [CW-1:0] stop_last;
  logic [BW-1:0] bit_last;
  logic          bit_end;
  logic          stop_end;

  assign adv       = tick_i & run_i;
  assign stop_last = CW'(stop_ticks(stop_sel_i, OS) - 1);
  assign bit_last  = wide_i ? BW'(W - 1) : BW'(W - 2);
  assign bit_end   = (cnt_q == CW'(OS - 1));
  assign stop_end  = (state_q == ST_STOP) && adv && (cnt_q >= stop_last);

  // reload on the stop-end tick keeps frames gapless
  assign take_o = pend_i & run_i & ((state_q == ST_IDLE) | stop_end);
  assign done_o = stop_end & ~take_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else if (take_o) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= pend_data_i;
    end else if (adv) begin
      unique case (state_q)
        ST_START: begin
          if (bit_end) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= sh_q >> 1;
            if (bit_q >= bit_last) state_q <= ST_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q >= stop_last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  p_hold_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !run_i) |=> (state_q == ST_IDLE));

  p_bit_index_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(bit_q) < W));

  p_no_start_unloaded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q == ST_IDLE || $past(pend_i)));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int W  = 9,
  parameter int OS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tx_en_i,
  input  logic         wide_i,
  input  logic [1:0]   stop_sel_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         txe_ie_i,
  input  logic         tc_ie_i,
  output logic         tx_o,
  output logic         txe_o,
  output logic         tc_o,
  output logic         txe_irq_o,
  output logic         tc_irq_o
);

  logic         run;
  logic         full;
  logic         accept;
  logic         take;
  logic         done;
  logic [W-1:0] hold_data;
  logic         tc_q;

  assign run = en_i & tx_en_i;

  uart_tx_hold #(.W(W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (full),
    .accept_o  (accept),
    .data_o    (hold_data)
  );

  uart_tx_shift #(.W(W), .OS(OS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (tick_i),
    .wide_i      (wide_i),
    .stop_sel_i  (stop_sel_i),
    .pend_i      (full),
    .pend_data_i (hold_data),
    .take_o      (take),
    .done_o      (done),
    .tx_o        (tx_o)
  );

  // an accepted write wins over a same-cycle frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tc_q <= 1'b1;
    else if (accept) tc_q <= 1'b0;
    else if (done)   tc_q <= 1'b1;
  end

  assign txe_o     = ~full;
  assign tc_o      = tc_q;
  assign txe_irq_o = txe_ie_i & ~full;
  assign tc_irq_o  = tc_ie_i & tc_q;

  p_tc_means_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |-> !full);

  p_tc_line_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_q) |-> tx_o);

  p_wr_clears_tc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full) |=> !tc_q);

endmodule

// File: tb/tb_uart_tx_dbuf.sv
`timescale 1ns/1ps
module tb_uart_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, tx_en = 1'b0, cfg_wide = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic       tick = 1'b0, wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       txe_ie = 1'b0, tc_ie = 1'b0;
  logic       tx, txe, tc, txe_irq, tc_irq;

  int vec = 0, bad = 0;
  int rx_n = 0;
  logic [8:0] rx_word [64];
  int         rx_gap  [64];
  longint     rx_t0   [64];
  bit trk = 0, tc_hi = 0;

  always #2.5 clk = ~clk;

  uart_tx_dbuf dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tx_en_i(tx_en), .wide_i(cfg_wide),
    .stop_sel_i(cfg_stop), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .txe_ie_i(txe_ie), .tc_ie_i(tc_ie), .tx_o(tx), .txe_o(txe), .tc_o(tc),
    .txe_irq_o(txe_irq), .tc_irq_o(tc_irq)
  );

  // oversample tick every 4 clocks
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      tick = (k % 4 == 3);
      k++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (trk && tc) tc_hi = 1;
  end

  task automatic chk(input string req, input bit ok, input string what,
                     input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stop_len(input logic [1:0] s);
    case (s)
      2'b01:   return 8;
      2'b10:   return 32;
      2'b11:   return 24;
      default: return 16;
    endcase
  endfunction

  function automatic logic [8:0] exp_word(input logic [8:0] d, input logic w);
    return w ? d : {1'b0, d[7:0]};
  endfunction

  // line monitor: mid-bit sampling, stop gap and start times
  initial begin
    bit pend = 0;
    longint t0, tr, tf;
    int nb, gap;
    logic [8:0] w;
    @(posedge rst_n);
    forever begin
      if (!pend) begin
        @(negedge clk);
        while (tx !== 1'b0) @(negedge clk);
      end
      pend = 0;
      t0 = $time / 5;
      nb = cfg_wide ? 9 : 8;
      repeat (30) @(negedge clk);
      chk("R5", tx === 1'b0, "start bit level", tx, 0);
      w = '0;
      for (int k = 0; k < nb; k++) begin
        repeat (k == 0 ? 66 : 64) @(negedge clk);
        w[k] = tx;
      end
      gap = -1;
      if (w[nb-1] == 1'b0) begin
        while (tx !== 1'b1) @(negedge clk);
        tr = $time / 5;
        for (int c = 0; c < 136; c++) begin
          @(negedge clk);
          if (tx === 1'b0) begin
            tf = $time / 5;
            gap = int'(tf - tr);
            pend = 1;
            break;
          end
        end
      end
      if (rx_n < 64) begin
        rx_word[rx_n] = w;
        rx_gap[rx_n]  = gap;
        rx_t0[rx_n]   = t0;
      end
      rx_n++;
    end
  end

  task automatic put(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_txe;
    @(negedge clk);
    while (!txe) @(negedge clk);
  endtask

  task automatic wait_tc;
    @(negedge clk);
    while (!tc) @(negedge clk);
    repeat (150) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    bit tx_hi;
    int base;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", tx == 1'b1, "idle line", tx, 1);
    chk("R1", txe == 1'b1, "empty flag", txe, 1);
    chk("R1", tc == 1'b1, "complete flag", tc, 1);
    chk("R1", !txe_irq && !tc_irq, "irqs off", {txe_irq, tc_irq}, 0);
    txe_ie = 1; tc_ie = 1;
    @(negedge clk);
    chk("R9", txe_irq && tc_irq, "irqs follow flags", {txe_irq, tc_irq}, 3);

    // R2 / R3 gating and dropped write
    tx_en = 1'b1;
    put(9'h0A5);
    chk("R3", txe == 1'b0 && tc == 1'b0, "write clears flags", {txe, tc}, 0);
    chk("R9", !txe_irq && !tc_irq, "irqs drop with flags", {txe_irq, tc_irq}, 0);
    put(9'h03C);
    tx_hi = 1;
    repeat (200) begin @(negedge clk); if (!tx) tx_hi = 0; end
    chk("R2", tx_hi && !txe, "no frame with en low", tx_hi, 1);
    en = 1'b1; tx_en = 1'b0;
    repeat (100) begin @(negedge clk); if (!tx) tx_hi = 0; end
    chk("R2", tx_hi && !txe, "no frame with tx_en low", tx_hi, 1);
    tc_ie = 0;
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4", txe == 1'b1, "empty after move", txe, 1);
    chk("R8", tc == 1'b0, "complete low in frame", tc, 0);
    chk("R9", txe_irq && !tc_irq, "irq enables", {txe_irq, tc_irq}, 2);
    wait_tc();
    chk("R3", rx_n == 1, "frames after dropped write", rx_n, 1);
    chk("R5", rx_word[0] == 9'h0A5, "first word", rx_word[0], 9'h0A5);
    chk("R8", tx == 1'b1 && tc_irq == 1'b0, "idle, tc irq masked", {tx, tc_irq}, 2);
    tc_ie = 1;
    @(negedge clk);
    chk("R9", tc_irq == 1'b1, "tc irq", tc_irq, 1);

    // back-to-back frames for each stop code, both widths
    for (int s = 0; s < 8; s++) begin
      logic [8:0] d0, d1, d2;
      int L, nb;
      cfg_stop = 2'(s % 4);
      cfg_wide = (s >= 4);
      nb = cfg_wide ? 9 : 8;
      L = stop_len(cfg_stop);
      d0 = 9'($urandom) & (cfg_wide ? 9'h0FF : 9'h07F);
      d1 = 9'($urandom) & (cfg_wide ? 9'h0FF : 9'h07F);
      d2 = 9'($urandom) & (cfg_wide ? 9'h0FF : 9'h07F);
      base = rx_n;
      tc_hi = 0;
      put(d0);
      trk = 1;
      wait_txe();
      put(d1);
      wait_txe();
      put(d2);
      wait_txe();
      trk = 0;
      chk("R7", tc_hi == 0, "complete stayed low between frames", tc_hi, 0);
      wait_tc();
      chk("R5", rx_n == base + 3, "frame count", rx_n, base + 3);
      chk("R5", rx_word[base] == d0 && rx_word[base+1] == d1 && rx_word[base+2] == d2,
          "words", rx_word[base+1], d1);
      chk("R6", rx_gap[base] == 4 * L, "stop length", rx_gap[base], 4 * L);
      chk("R7", rx_gap[base+1] == 4 * L, "gapless restart", rx_gap[base+1], 4 * L);
      chk("R10", rx_t0[base+2] - rx_t0[base+1] == longint'((1 + nb) * 64 + 4 * L),
          "frame period", rx_t0[base+2] - rx_t0[base+1], (1 + nb) * 64 + 4 * L);
    end

    // random words, widths and stop codes
    for (int i = 0; i < 30; i++) begin
      logic [8:0] d0, d1;
      bit two;
      cfg_wide = 1'($urandom);
      cfg_stop = 2'($urandom);
      d0 = 9'($urandom);
      d1 = 9'($urandom);
      two = 1'($urandom);
      base = rx_n;
      put(d0);
      if (two) begin
        wait_txe();
        put(d1);
      end
      wait_tc();
      chk("R5", rx_n == base + (two ? 2 : 1), "random frame count", rx_n, base + (two ? 2 : 1));
      if (base < 64)
        chk("R5", rx_word[base] == exp_word(d0, cfg_wide), "random word",
            rx_word[base], exp_word(d0, cfg_wide));
      if (two && base + 1 < 64)
        chk("R5", rx_word[base+1] == exp_word(d1, cfg_wide), "random second word",
            rx_word[base+1], exp_word(d1, cfg_wide));
      chk("R8", tc && txe && tx, "idle after random", {tc, txe, tx}, 7);
    end

    summary();
  end

endmodule